// File: doc/BRIEF.md
# Dual-Channel Access-Triggered Interrupt Gate

This block sits between two disk-drive channels and a host bus and folds the two raw drive interrupt requests into a single card interrupt line. Each channel has a gate bit. The bus can only change a gate through the kind of access it makes to that channel's gate address. A write of any value opens the gate. A read of that address closes it. No data bit is ever decoded to change a gate.

A separate status address for each channel returns that channel's raw interrupt in bit 0, whether or not the gate is open. The card interrupt output is high while at least one channel has its gate open and its raw request high.

A parameter selects the layout. The default layout has two channels. The alternative layout has one channel, with its status at address 0x0 and its gate at 0x4.

Top module: `dual_irq_gate`

## Requirements
- R1: After reset both gates are closed, `card_irq` is low and `bus_rdata` is zero.
- R2: A cycle with `bus_wr` high at a channel's gate address opens that gate from the next clock edge on, whatever the value of `bus_wdata`. In the two-channel layout the gate addresses are 0x2200 for channel 0 and 0x3200 for channel 1.
- R3: A cycle with `bus_rd` high and `bus_wr` low at a channel's gate address closes that gate from the next clock edge on. In the cycle after that read, `bus_rdata` is all zeros.
- R4: A read at a channel's status address returns that channel's raw interrupt, as it was in the read cycle, in bit 0 of `bus_rdata` one cycle later. All other bits are zero, and the gate state does not matter. In the two-channel layout the status addresses are 0x2290 for channel 0 and 0x3290 for channel 1. A status read leaves the gates unchanged.
- R5: `card_irq` is high exactly when some channel has its gate open and its `raw_irq` bit high. It follows `raw_irq` in the same cycle.
- R6: A read or write at any address other than the gate and status addresses leaves both gates unchanged. A read there returns zero one cycle later.
- R7: When `bus_rd` and `bus_wr` are both high at a gate address, the write takes priority and the gate opens.
- R8: With `SINGLE=1` there is one channel. Its status is at 0x0 and its gate at 0x4, and the same open-on-write and close-on-read rules apply.
- R9: In every cycle without a read, the next `bus_rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | DATA_W | Write data, never decoded |
| raw_irq | input | NCH | Raw interrupt request from each drive channel |
| bus_rdata | output | DATA_W | Read data, valid in the cycle after `bus_rd` |
| card_irq | output | 1 | Combined, gated card interrupt |

## Verification
The assertions assume that `raw_irq` is synchronous to `clk` and holds its value for the whole cycle. They also assume that each access presents a single address, with the strobes qualifying it. The stimulus changes every input, including the raw requests, only on the falling edge, so no assertion sees an input move between edges. The random address mix favours the four decoded addresses and adds unmapped addresses and overlapping read and write strobes. This keeps open, close and priority events frequent while the raw requests toggle under them.

// File: rtl/dual_irq_gate_pkg.sv
package dual_irq_gate_pkg;

   localparam int DUAL_GATE_BASE = 32'h2200;
   localparam int DUAL_STAT_BASE = 32'h2290;
   localparam int DUAL_CH_STRIDE = 32'h1000;
   localparam int SOLO_STAT_ADDR = 32'h0;
   localparam int SOLO_GATE_ADDR = 32'h4;

   function automatic int gate_addr(input bit single, input int ch);
      return single ? SOLO_GATE_ADDR : DUAL_GATE_BASE + ch * DUAL_CH_STRIDE;
   endfunction

   function automatic int stat_addr(input bit single, input int ch);
      return single ? SOLO_STAT_ADDR : DUAL_STAT_BASE + ch * DUAL_CH_STRIDE;
   endfunction

   function automatic int min_addr_w(input bit single);
      return single ? 3 : 14;
   endfunction

endpackage

// File: rtl/dual_irq_gate_decode.sv
module dual_irq_gate_decode
   import dual_irq_gate_pkg::*;
#(
   parameter bit SINGLE = 1'b0,
   parameter int ADDR_W = 14,
   parameter int NCH    = 2
) (
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   output logic [NCH-1:0]    gate_set,
   output logic [NCH-1:0]    gate_clr,
   output logic [NCH-1:0]    stat_sel
);
   for (genvar c = 0; c < NCH; c++) begin : g_ch
      localparam logic [ADDR_W-1:0] GATE_A = ADDR_W'(gate_addr(SINGLE, c));
      localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(stat_addr(SINGLE, c));
      logic gate_hit;
      assign gate_hit    = (bus_addr == GATE_A);
      assign gate_set[c] = bus_wr & gate_hit;
      assign gate_clr[c] = bus_rd & ~bus_wr & gate_hit;
      assign stat_sel[c] = bus_rd & (bus_addr == STAT_A);
   end
endmodule

// File: rtl/dual_irq_gate_bank.sv
module dual_irq_gate_bank #(
   parameter int NCH = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NCH-1:0] gate_set,
   input  logic [NCH-1:0] gate_clr,
   output logic [NCH-1:0] gate_q
);
   for (genvar c = 0; c < NCH; c++) begin : g_bit
      always_ff @(posedge clk) begin
         if (!rst_n)           gate_q[c] <= 1'b0;
         else if (gate_set[c]) gate_q[c] <= 1'b1;
         else if (gate_clr[c]) gate_q[c] <= 1'b0;
      end
   end
endmodule

// File: rtl/dual_irq_gate_rdmux.sv
module dual_irq_gate_rdmux #(
   parameter int NCH    = 2,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NCH-1:0]    stat_sel,
   input  logic [NCH-1:0]    raw_irq,
   output logic [DATA_W-1:0] bus_rdata
);
   logic stat_bit;
   assign stat_bit = |(stat_sel & raw_irq);

   always_ff @(posedge clk) begin
      if (!rst_n) bus_rdata <= '0;
      else        bus_rdata <= DATA_W'(stat_bit);
   end
endmodule

// File: rtl/dual_irq_gate.sv
module dual_irq_gate
   import dual_irq_gate_pkg::*;
#(
   parameter bit SINGLE = 1'b0,
   parameter int ADDR_W = 14,
   parameter int DATA_W = 8,
   localparam int NCH   = SINGLE ? 1 : 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic [NCH-1:0]    raw_irq,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              card_irq
);
   if (ADDR_W < min_addr_w(SINGLE)) begin : g_bad_addr_w
      $error("dual_irq_gate: ADDR_W too narrow for the selected layout");
   end
   if (DATA_W < 1) begin : g_bad_data_w
      $error("dual_irq_gate: DATA_W must be at least 1");
   end

   logic [NCH-1:0] gate_set;
   logic [NCH-1:0] gate_clr;
   logic [NCH-1:0] stat_sel;
   logic [NCH-1:0] gate_q;
   logic           wdata_unused;

   assign wdata_unused = ^bus_wdata;

   dual_irq_gate_decode #(.SINGLE(SINGLE), .ADDR_W(ADDR_W), .NCH(NCH)) u_decode (
      .bus_rd   (bus_rd),
      .bus_wr   (bus_wr),
      .bus_addr (bus_addr),
      .gate_set (gate_set),
      .gate_clr (gate_clr),
      .stat_sel (stat_sel)
   );

   dual_irq_gate_bank #(.NCH(NCH)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .gate_set (gate_set),
      .gate_clr (gate_clr),
      .gate_q   (gate_q)
   );

   dual_irq_gate_rdmux #(.NCH(NCH), .DATA_W(DATA_W)) u_rdmux (
      .clk       (clk),
      .rst_n     (rst_n),
      .stat_sel  (stat_sel),
      .raw_irq   (raw_irq),
      .bus_rdata (bus_rdata)
   );

   assign card_irq = |(gate_q & raw_irq);
endmodule

// File: rtl/dual_irq_gate_chk.sv
module dual_irq_gate_chk
   import dual_irq_gate_pkg::*;
#(
   parameter bit SINGLE = 1'b0,
   parameter int ADDR_W = 14,
   parameter int DATA_W = 8,
   parameter int NCH    = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_rd,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [NCH-1:0]    raw_irq,
   input logic [NCH-1:0]    gate_q,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              card_irq
);
   logic any_hit;
   always_comb begin
      any_hit = 1'b0;
      for (int c = 0; c < NCH; c++) begin
         if (bus_addr == ADDR_W'(gate_addr(SINGLE, c)) ||
             bus_addr == ADDR_W'(stat_addr(SINGLE, c)))
            any_hit = 1'b1;
      end
   end

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      localparam logic [ADDR_W-1:0] GA = ADDR_W'(gate_addr(SINGLE, c));
      localparam logic [ADDR_W-1:0] SA = ADDR_W'(stat_addr(SINGLE, c));

      // R2
      gate_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_wr && bus_addr == GA) |=> gate_q[c]);
      // R3
      gate_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_rd && !bus_wr && bus_addr == GA) |=> (!gate_q[c] && bus_rdata == '0));
      // R4
      stat_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_rd && !bus_wr && bus_addr == SA) |=>
            (bus_rdata == DATA_W'($past(raw_irq[c])) && $stable(gate_q)));
      // R5
      irq_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (gate_q[c] && raw_irq[c]) |-> card_irq);
   end

   // R5
   irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      card_irq |-> |raw_irq);
   // R6
   unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((bus_rd || bus_wr) && !any_hit) |=> ($stable(gate_q) && bus_rdata == '0));
   // R9
   idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> bus_rdata == '0);
endmodule

bind dual_irq_gate dual_irq_gate_chk #(
   .SINGLE(SINGLE), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NCH(NCH)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_rd    (bus_rd),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .raw_irq   (raw_irq),
   .gate_q    (gate_q),
   .bus_rdata (bus_rdata),
   .card_irq  (card_irq)
);

// File: tb/test_dual_irq_gate.sv
`timescale 1ns/1ps
module test_dual_irq_gate;
   localparam int AW = 14;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_rd = 1'b0, bus_wr = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [DW-1:0] bus_wdata = '0;
   logic [1:0]    raw_irq = '0;
   logic [DW-1:0] rdata_d, rdata_s;
   logic          irq_d, irq_s;

   int checks = 0, failures = 0;
   logic [1:0] m_gate = '0;
   logic       m_solo = 1'b0;

   always #2.5 clk = ~clk;

   dual_irq_gate #(.SINGLE(1'b0), .ADDR_W(AW), .DATA_W(DW)) i_dual_irq_gate (
      .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .raw_irq(raw_irq),
      .bus_rdata(rdata_d), .card_irq(irq_d));

   dual_irq_gate #(.SINGLE(1'b1), .ADDR_W(AW), .DATA_W(DW)) i_dual_irq_gate_solo (
      .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .raw_irq(raw_irq[0]),
      .bus_rdata(rdata_s), .card_irq(irq_s));

   function automatic logic [1:0] next_gate(input logic [1:0] g, input logic rd,
         input logic wr, input logic [AW-1:0] a);
      logic [1:0] n = g;
      if (a == 14'h2200) n[0] = wr ? 1'b1 : (rd ? 1'b0 : g[0]);
      if (a == 14'h3200) n[1] = wr ? 1'b1 : (rd ? 1'b0 : g[1]);
      return n;
   endfunction

   function automatic logic [DW-1:0] dual_rd(input logic rd, input logic [AW-1:0] a,
         input logic [1:0] raw);
      if (rd && a == 14'h2290) return DW'(raw[0]);
      if (rd && a == 14'h3290) return DW'(raw[1]);
      return '0;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic access(input logic rd, input logic wr, input logic [AW-1:0] a,
         input logic [DW-1:0] wd, input logic [1:0] raw, input string req);
      logic [DW-1:0] e_d, e_s;
      @(negedge clk);
      bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = wd; raw_irq = raw;
      e_d = dual_rd(rd, a, raw);
      e_s = (rd && a == 14'h0) ? DW'(raw[0]) : '0;
      m_gate = next_gate(m_gate, rd, wr, a);
      if (a == 14'h4) m_solo = wr ? 1'b1 : (rd ? 1'b0 : m_solo);
      @(posedge clk); #1;
      check(rdata_d == e_d, req, rdata_d, e_d);
      check(irq_d == |(m_gate & raw), {req, "/R5"}, irq_d, |(m_gate & raw));
      check(rdata_s == e_s, {req, "/R8"}, rdata_s, e_s);
      check(irq_s == (m_solo & raw[0]), {req, "/R8"}, irq_s, m_solo & raw[0]);
   endtask

   initial begin : watchdog
      #500us;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(posedge clk);
      #1;
      // R1 reset state
      check(rdata_d == 0 && irq_d == 0, "R1", {rdata_d, irq_d}, 0);
      @(negedge clk); rst_n = 1'b1; raw_irq = 2'b11;
      @(posedge clk); #1;
      check(irq_d == 0 && irq_s == 0, "R1 gates closed", {irq_d, irq_s}, 0);
      // R2 open with arbitrary data
      access(1'b0, 1'b1, 14'h2200, 8'h00, 2'b01, "R2");
      check(irq_d == 1'b1, "R2 open ch0", irq_d, 1);
      // R4 status independent of gate
      access(1'b1, 1'b0, 14'h3290, 8'h00, 2'b10, "R4");
      check(rdata_d == 8'h01 && irq_d == 0, "R4 ch1 status gate closed", rdata_d, 1);
      // R3 close by read, data zero
      access(1'b1, 1'b0, 14'h2200, 8'h00, 2'b11, "R3");
      check(irq_d == 0 && rdata_d == 0, "R3 closed ch0", {rdata_d, irq_d}, 0);
      // R6 unmapped write/read
      access(1'b0, 1'b1, 14'h2201, 8'hFF, 2'b11, "R6");
      access(1'b1, 1'b0, 14'h1234, 8'hFF, 2'b11, "R6");
      check(irq_d == 0, "R6 no open", irq_d, 0);
      // R7 write wins
      access(1'b1, 1'b1, 14'h3200, 8'h5A, 2'b10, "R7");
      check(irq_d == 1, "R7 write priority", irq_d, 1);
      // R9 idle rdata
      access(1'b0, 1'b0, 14'h2290, 8'h00, 2'b11, "R9");
      // R8 solo layout
      access(1'b0, 1'b1, 14'h4, 8'h33, 2'b01, "R8");
      check(irq_s == 1, "R8 solo open", irq_s, 1);
      access(1'b1, 1'b0, 14'h0, 8'h00, 2'b01, "R8");
      access(1'b1, 1'b0, 14'h4, 8'h00, 2'b01, "R8");
      check(irq_s == 0, "R8 solo closed", irq_s, 0);
      // random mix
      for (int i = 0; i < 1500; i++) begin
         logic [AW-1:0] a;
         case ($urandom_range(0, 6))
            0: a = 14'h2200;
            1: a = 14'h3200;
            2: a = 14'h2290;
            3: a = 14'h3290;
            4: a = 14'h0;
            5: a = 14'h4;
            default: a = AW'($urandom);
         endcase
         access(1'($urandom), 1'($urandom), a, DW'($urandom), 2'($urandom), "R2-mix");
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule